// File: doc/BRIEF.md
# Dual-flash quad SPI bus router

This block drives two external quad SPI flash devices from a byte-oriented transfer interface. Each transfer is started with a configuration sampled in the same cycle: the bus arrangement (parallel or stacked), the target (lower device, upper device or both), byte striping, the line width (one line or four lines per device), the direction and the byte count. The block then serializes and deserializes on its own pins, routing and merging the byte streams to match that configuration.

In parallel arrangement the two devices share the serial clock and a common select, and each owns its own four data lines, eight in total. With striping on, even-numbered bytes travel on the lower bus and odd-numbered bytes on the upper bus, both lanes moving on the same clock edges. In stacked arrangement both devices hang on one set of four lines, the lower pins, and only the addressed device sees its select fall. Configurations that cannot be honoured are refused and raise a sticky error flag.

Top module: `dfr_router`

## Requirements
- R1: While no transfer runs, both active-low selects are high, the serial clock is low, every output enable is 0 and `busy` is low; this is also the state after reset.
- R2: A `start` while idle with a legal configuration makes `busy` rise the next cycle. A transfer lasts beats × bit-times × 2 clocks. Each bit-time is two clocks, with `sclk` low and then high. Beats equal `cfg_len/2` with striping and `cfg_len` without.
- R3: In parallel arrangement (`cfg_stacked`=0) both selects are low for the whole transfer. The lower pins carry data when target bit 0 is set and the upper pins when target bit 1 is set (target 2'b01 lower, 2'b10 upper, 2'b11 both).
- R4: In stacked arrangement (`cfg_stacked`=1) all data uses the lower pins and the upper pins are never driven. Only `cs_lo_n` falls for target 2'b01, and only `cs_hi_n` falls for target 2'b10.
- R5: With striping, byte 2k goes out on the lower bus and byte 2k+1 on the upper bus. On write, `tx_data[7:0]` holds the even byte and `tx_data[15:8]` the odd byte. On read, `rx_data` returns them in the same positions.
- R6: In parallel arrangement with target 2'b11 and no striping, the same byte (`tx_data[7:0]`) goes out on both buses, and a read returns the lower bus byte.
- R7: In quad width (`cfg_quad`=1) a write drives all four lines of an active bus (enable 4'hF), high nibble first, so a byte takes two bit-times. In single width a write drives only line 0 (enable 4'h1), MSB first, so a byte takes eight bit-times. A single-width read samples only line 1.
- R8: During a read every output enable is 0, and `rx_valid` pulses for one cycle right after the last bit-time of each beat. Without striping, `rx_data[15:8]` is 0 and `rx_data[7:0]` comes from the upper pins for a parallel upper-only read, or from the lower pins otherwise.
- R9: No transfer starts and `err` is set when `start` arrives while idle with any of these: length 0, target 2'b00, stacked arrangement with target 2'b11, or striping unless the arrangement is parallel with target 2'b11 and an even length.
- R10: `err` stays set until `err_clr` is high. A rejection in the same cycle as `err_clr` leaves it set.
- R11: A `start` while `busy` is high is ignored. The running transfer keeps its configuration and length.
- R12: `tx_req` is high, for writes only, in each cycle where a beat's data is taken from `tx_data`. These are the accepting cycle and the last cycle of every beat except the final one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer with the cfg_* values of this cycle |
| cfg_stacked | input | 1 | 0 parallel arrangement, 1 stacked arrangement |
| cfg_tgt | input | 2 | Target: 01 lower, 10 upper, 11 both |
| cfg_stripe | input | 1 | Byte striping across the two buses |
| cfg_quad | input | 1 | 1 four lines per bus, 0 one line each way |
| cfg_rd | input | 1 | 1 read from flash, 0 write to flash |
| cfg_len | input | LEN_W | Transfer length in bytes |
| err_clr | input | 1 | Clears the sticky error flag |
| tx_data | input | 16 | Write data: even byte low, odd byte high |
| tx_req | output | 1 | tx_data is consumed this cycle |
| rx_valid | output | 1 | rx_data holds a new beat |
| rx_data | output | 16 | Read data: even byte low, odd byte high |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Sticky rejected-configuration flag |
| sclk | output | 1 | Shared serial clock |
| cs_lo_n | output | 1 | Lower device select, active low |
| cs_hi_n | output | 1 | Upper device select, active low |
| io_lo_o | output | 4 | Lower bus output data |
| io_lo_oe | output | 4 | Lower bus per-line output enable |
| io_lo_i | input | 4 | Lower bus input data |
| io_hi_o | output | 4 | Upper bus output data |
| io_hi_oe | output | 4 | Upper bus per-line output enable |
| io_hi_i | input | 4 | Upper bus input data |

## Verification
Selects, serial clock, enables and `busy` change in the cycle after the accepting edge and fall in the cycle after the final bit-time edge. The error flag appears one cycle after a refused `start`, and `rx_valid` one cycle after the edge that closes a beat. `tx_req` is combinational and is due in the accepting cycle itself. The bench keeps a per-clock timeline, indexed by clocks since acceptance, that predicts each of these and compares it half a cycle after every edge. Byte content is compared after the run against the bytes seen by bench-side device models on the pins.

// File: rtl/dfr_pkg.sv
`timescale 1ns/1ps
package dfr_pkg;

  typedef enum logic {
    ARR_PARALLEL = 1'b0,
    ARR_STACKED  = 1'b1
  } arr_e;

  localparam logic [1:0] TGT_NONE = 2'b00;
  localparam logic [1:0] TGT_LO   = 2'b01;
  localparam logic [1:0] TGT_HI   = 2'b10;
  localparam logic [1:0] TGT_BOTH = 2'b11;

  typedef struct packed {
    arr_e       arr;
    logic [1:0] tgt;
    logic       stripe;
    logic       quad;
    logic       rd;
  } xfer_cfg_t;

  localparam int LANES  = 2;
  localparam int BUS_W  = 4;
  localparam int BYTE_W = 8;

endpackage

// File: rtl/dfr_cfg_check.sv
`timescale 1ns/1ps
module dfr_cfg_check
  import dfr_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  xfer_cfg_t        cfg,
  input  logic [LEN_W-1:0] len,
  output logic             ok
);

  logic len_zero;
  logic tgt_bad;
  logic stk_both;
  logic stripe_bad;

  always_comb begin
    len_zero   = (len == '0);
    tgt_bad    = (cfg.tgt == TGT_NONE);
    stk_both   = (cfg.arr == ARR_STACKED) && (cfg.tgt == TGT_BOTH);
    stripe_bad = cfg.stripe &&
                 ((cfg.arr == ARR_STACKED) || (cfg.tgt != TGT_BOTH) || len[0]);
    ok         = !(len_zero || tgt_bad || stk_both || stripe_bad);
  end

endmodule

// File: rtl/dfr_lane.sv
`timescale 1ns/1ps
module dfr_lane
  import dfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              shift,
  input  logic              quad,
  input  logic              drive,
  input  logic [BUS_W-1:0]  pin_i,
  output logic [BUS_W-1:0]  pin_o,
  output logic [BUS_W-1:0]  pin_oe,
  output logic [BYTE_W-1:0] sh_nxt
);

  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] sh_d;

  always_comb begin
    if (quad) sh_nxt = {sh_q[BYTE_W-BUS_W-1:0], pin_i};
    else      sh_nxt = {sh_q[BYTE_W-2:0], pin_i[1]};

    sh_d = sh_q;
    if (load)       sh_d = load_byte;
    else if (shift) sh_d = sh_nxt;

    if (quad) pin_o = sh_q[BYTE_W-1:BYTE_W-BUS_W];
    else      pin_o = {{(BUS_W-1){1'b0}}, sh_q[BYTE_W-1]};

    if (!drive)    pin_oe = '0;
    else if (quad) pin_oe = '1;
    else           pin_oe = {{(BUS_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

endmodule

// File: rtl/dfr_seq.sv
`timescale 1ns/1ps
module dfr_seq
  import dfr_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cfg_ok,
  input  xfer_cfg_t        cfg_in,
  input  logic [LEN_W-1:0] len_in,
  output logic             accept,
  output logic             run,
  output logic             ph,
  output logic             bit_end,
  output logic             beat_end,
  output logic             last_beat,
  output xfer_cfg_t        cfg_q
);

  localparam int BT_W = $clog2(BYTE_W);

  logic             run_q, run_d;
  logic             ph_q, ph_d;
  logic [BT_W-1:0]  bt_q, bt_d;
  logic [LEN_W-1:0] beats_q, beats_d;
  xfer_cfg_t        cfg_d;
  logic [BT_W-1:0]  bt_last;

  always_comb begin
    bt_last   = cfg_q.quad ? BT_W'(BYTE_W/BUS_W - 1) : BT_W'(BYTE_W - 1);
    accept    = !run_q && start && cfg_ok;
    bit_end   = run_q && ph_q;
    beat_end  = bit_end && (bt_q == bt_last);
    last_beat = (beats_q == LEN_W'(1));

    run_d   = run_q;
    ph_d    = ph_q;
    bt_d    = bt_q;
    beats_d = beats_q;
    cfg_d   = cfg_q;

    if (accept) begin
      run_d   = 1'b1;
      ph_d    = 1'b0;
      bt_d    = '0;
      beats_d = cfg_in.stripe ? (len_in >> 1) : len_in;
      cfg_d   = cfg_in;
    end else if (run_q) begin
      ph_d = !ph_q;
      if (bit_end) bt_d = beat_end ? '0 : bt_q + BT_W'(1);
      if (beat_end) begin
        beats_d = beats_q - LEN_W'(1);
        if (last_beat) run_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ph_q    <= 1'b0;
      bt_q    <= '0;
      beats_q <= '0;
      cfg_q   <= '0;
    end else begin
      run_q   <= run_d;
      ph_q    <= ph_d;
      bt_q    <= bt_d;
      beats_q <= beats_d;
      cfg_q   <= cfg_d;
    end
  end

  assign run = run_q;
  assign ph  = ph_q;

endmodule

// File: rtl/dfr_router.sv
`timescale 1ns/1ps
module dfr_router
  import dfr_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cfg_stacked,
  input  logic [1:0]          cfg_tgt,
  input  logic                cfg_stripe,
  input  logic                cfg_quad,
  input  logic                cfg_rd,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                err_clr,
  input  logic [2*BYTE_W-1:0] tx_data,
  output logic                tx_req,
  output logic                rx_valid,
  output logic [2*BYTE_W-1:0] rx_data,
  output logic                busy,
  output logic                err,
  output logic                sclk,
  output logic                cs_lo_n,
  output logic                cs_hi_n,
  output logic [BUS_W-1:0]    io_lo_o,
  output logic [BUS_W-1:0]    io_lo_oe,
  input  logic [BUS_W-1:0]    io_lo_i,
  output logic [BUS_W-1:0]    io_hi_o,
  output logic [BUS_W-1:0]    io_hi_oe,
  input  logic [BUS_W-1:0]    io_hi_i
);

  xfer_cfg_t cfg_in;
  xfer_cfg_t cfg_q;
  logic      cfg_ok;
  logic      accept, run, ph, bit_end, beat_end, last_beat;
  logic      stk_q, rd_q;
  logic      stripe_eff;
  logic      load;

  logic [BYTE_W-1:0] lane_ld   [LANES];
  logic [BYTE_W-1:0] lane_nxt  [LANES];
  logic [BUS_W-1:0]  lane_pi   [LANES];
  logic [BUS_W-1:0]  lane_po   [LANES];
  logic [BUS_W-1:0]  lane_poe  [LANES];
  logic              lane_act  [LANES];
  logic              lane_drv  [LANES];

  logic                rxv_q, rxv_d;
  logic [2*BYTE_W-1:0] rxd_q, rxd_d;
  logic                err_q, err_d;
  logic [BYTE_W-1:0]   rx_src;

  assign cfg_in = '{arr:    cfg_stacked ? ARR_STACKED : ARR_PARALLEL,
                    tgt:    cfg_tgt,
                    stripe: cfg_stripe,
                    quad:   cfg_quad,
                    rd:     cfg_rd};

  dfr_cfg_check #(.LEN_W(LEN_W)) u_check (
    .cfg (cfg_in),
    .len (cfg_len),
    .ok  (cfg_ok)
  );

  dfr_seq #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_ok    (cfg_ok),
    .cfg_in    (cfg_in),
    .len_in    (cfg_len),
    .accept    (accept),
    .run       (run),
    .ph        (ph),
    .bit_end   (bit_end),
    .beat_end  (beat_end),
    .last_beat (last_beat),
    .cfg_q     (cfg_q)
  );

  always_comb begin
    stk_q      = (cfg_q.arr == ARR_STACKED);
    rd_q       = cfg_q.rd;
    stripe_eff = run ? cfg_q.stripe : cfg_in.stripe;
    load       = (accept && !cfg_in.rd) ||
                 (beat_end && !last_beat && !cfg_q.rd);
    lane_act[0] = run && (stk_q || cfg_q.tgt[0]);
    lane_act[1] = run && !stk_q && cfg_q.tgt[1];
    lane_ld[0]  = tx_data[BYTE_W-1:0];
    lane_ld[1]  = stripe_eff ? tx_data[2*BYTE_W-1:BYTE_W] : tx_data[BYTE_W-1:0];
    lane_pi[0]  = io_lo_i;
    lane_pi[1]  = io_hi_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_drv[g] = lane_act[g] && !cfg_q.rd;
    dfr_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_byte (lane_ld[g]),
      .shift     (bit_end),
      .quad      (cfg_q.quad),
      .drive     (lane_drv[g]),
      .pin_i     (lane_pi[g]),
      .pin_o     (lane_po[g]),
      .pin_oe    (lane_poe[g]),
      .sh_nxt    (lane_nxt[g])
    );
  end

  always_comb begin
    rx_src = (!stk_q && cfg_q.tgt == TGT_HI) ? lane_nxt[1] : lane_nxt[0];
    rxv_d  = beat_end && cfg_q.rd;
    rxd_d  = rxd_q;
    if (rxv_d) begin
      if (cfg_q.stripe) rxd_d = {lane_nxt[1], lane_nxt[0]};
      else              rxd_d = {{BYTE_W{1'b0}}, rx_src};
    end
    err_d = err_q;
    if (start && !run && !cfg_ok) err_d = 1'b1;
    else if (err_clr)             err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxv_q <= 1'b0;
      rxd_q <= '0;
      err_q <= 1'b0;
    end else begin
      rxv_q <= rxv_d;
      rxd_q <= rxd_d;
      err_q <= err_d;
    end
  end

  assign tx_req   = load;
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;
  assign busy     = run;
  assign err      = err_q;
  assign sclk     = run && ph;
  assign cs_lo_n  = !(run && (!stk_q || cfg_q.tgt == TGT_LO));
  assign cs_hi_n  = !(run && (!stk_q || cfg_q.tgt == TGT_HI));
  assign io_lo_o  = lane_po[0];
  assign io_lo_oe = lane_poe[0];
  assign io_hi_o  = lane_po[1];
  assign io_hi_oe = lane_poe[1];

endmodule

// File: rtl/dfr_router_chk.sv
`timescale 1ns/1ps
module dfr_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       err_clr,
  input logic       busy,
  input logic       err,
  input logic       sclk,
  input logic       cs_lo_n,
  input logic       cs_hi_n,
  input logic [3:0] io_lo_oe,
  input logic [3:0] io_hi_oe,
  input logic       rx_valid,
  input logic       cfg_ok,
  input logic       stk_q,
  input logic       rd_q
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_lo_n && cs_hi_n && !sclk && io_lo_oe == 4'h0 && io_hi_oe == 4'h0));

  assert_par_shared_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stk_q) |-> (!cs_lo_n && !cs_hi_n));

  assert_stk_one_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stk_q) |-> ((cs_lo_n != cs_hi_n) && io_hi_oe == 4'h0));

  assert_read_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_q) |-> (io_lo_oe == 4'h0 && io_hi_oe == 4'h0));

  assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !cfg_ok) |=> (!busy && err));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);

endmodule

bind dfr_router dfr_router_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .err_clr  (err_clr),
  .busy     (busy),
  .err      (err),
  .sclk     (sclk),
  .cs_lo_n  (cs_lo_n),
  .cs_hi_n  (cs_hi_n),
  .io_lo_oe (io_lo_oe),
  .io_hi_oe (io_hi_oe),
  .rx_valid (rx_valid),
  .cfg_ok   (cfg_ok),
  .stk_q    (stk_q),
  .rd_q     (rd_q)
);

// File: tb/test_dfr_router.sv
`timescale 1ns/1ps
module test_dfr_router;

  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start = 1'b0, err_clr = 1'b0;
  logic          b_stk = 1'b0, b_stripe = 1'b0, b_quad = 1'b0, b_rd = 1'b0;
  logic [1:0]    b_tgt = 2'b01;
  logic [LW-1:0] b_len = '0;
  logic [15:0]   tx_data;
  logic          tx_req, rx_valid, busy, err, sclk, cs_lo_n, cs_hi_n;
  logic [15:0]   rx_data;
  logic [3:0]    io_lo_o, io_lo_oe, io_lo_i, io_hi_o, io_hi_oe, io_hi_i;

  dfr_router #(.LEN_W(LW)) i_dfr_router (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_stacked(b_stk), .cfg_tgt(b_tgt),
    .cfg_stripe(b_stripe), .cfg_quad(b_quad), .cfg_rd(b_rd), .cfg_len(b_len),
    .err_clr(err_clr), .tx_data(tx_data), .tx_req(tx_req), .rx_valid(rx_valid),
    .rx_data(rx_data), .busy(busy), .err(err), .sclk(sclk), .cs_lo_n(cs_lo_n),
    .cs_hi_n(cs_hi_n), .io_lo_o(io_lo_o), .io_lo_oe(io_lo_oe), .io_lo_i(io_lo_i),
    .io_hi_o(io_hi_o), .io_hi_oe(io_hi_oe), .io_hi_i(io_hi_i));

  int total = 0, bad = 0;
  logic [7:0] txb [64];
  logic [7:0] rlo [32];
  logic [7:0] rhi [32];
  logic [7:0]  q_lo[$], q_hi[$];
  logic [15:0] q_rx[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit cfg_good(input logic stk, input logic [1:0] tgt, input logic stripe, input logic [LW-1:0] len);
    if (len == 0) return 1'b0;
    if (tgt == 2'b00) return 1'b0;
    if (stk && tgt == 2'b11) return 1'b0;
    if (stripe && (stk || tgt != 2'b11 || len[0])) return 1'b0;
    return 1'b1;
  endfunction

  // behavioural timeline: clocks remaining in the running transfer
  int m_cnt = 0, m_tot = 0, m_cpb = 4, tx_i = 0;
  logic m_stk = 0, m_rd = 0, m_quad = 0, m_err = 0, m_rxv = 0;
  logic [1:0] m_tgt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_err <= 0; m_rxv <= 0; tx_i <= 0;
    end else begin
      m_rxv <= (m_cnt > 0) && m_rd && (((m_tot - m_cnt) % m_cpb) == m_cpb - 1);
      if (start && m_cnt == 0 && !cfg_good(b_stk, b_tgt, b_stripe, b_len)) m_err <= 1'b1;
      else if (err_clr) m_err <= 1'b0;
      if (m_cnt == 0 && start && cfg_good(b_stk, b_tgt, b_stripe, b_len)) begin
        m_cpb <= b_quad ? 4 : 16;
        m_tot <= (b_stripe ? int'(b_len) / 2 : int'(b_len)) * (b_quad ? 4 : 16);
        m_cnt <= (b_stripe ? int'(b_len) / 2 : int'(b_len)) * (b_quad ? 4 : 16);
        m_stk <= b_stk; m_tgt <= b_tgt; m_rd <= b_rd; m_quad <= b_quad;
        tx_i  <= tx_req ? 1 : 0;
      end else begin
        if (m_cnt > 0) m_cnt <= m_cnt - 1;
        if (tx_req) tx_i <= tx_i + 1;
        else if (m_cnt == 0) tx_i <= 0;
      end
    end
  end

  always_comb begin
    if (b_stripe) tx_data = {txb[(2*tx_i+1) & 63], txb[(2*tx_i) & 63]};
    else          tx_data = {8'h00, txb[tx_i & 63]};
  end

  // device models drive the read data
  always_comb begin
    int idx, bt, beat, w;
    logic [7:0] bl, bh;
    io_lo_i = 4'hA; io_hi_i = 4'hA;
    if (m_cnt > 0) begin
      idx = m_tot - m_cnt; bt = idx / 2;
      beat = bt / (m_cpb / 2); w = bt % (m_cpb / 2);
      bl = rlo[beat & 31]; bh = rhi[beat & 31];
      if (m_quad) begin
        io_lo_i = (w == 0) ? bl[7:4] : bl[3:0];
        io_hi_i = (w == 0) ? bh[7:4] : bh[3:0];
      end else begin
        io_lo_i = {2'b10, bl[7-w], ~bl[7-w]};
        io_hi_i = {2'b10, bh[7-w], ~bh[7-w]};
      end
    end
  end

  // per-clock comparison and pin capture, half a cycle after each edge
  logic [7:0] acc_lo, acc_hi;
  int nb_lo = 0, nb_hi = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      int idx;
      logic xb, xtr;
      logic [3:0] xoe_lo, xoe_hi;
      idx = m_tot - m_cnt;
      xb = (m_cnt > 0);
      xoe_lo = (xb && !m_rd && (m_stk || m_tgt[0])) ? (m_quad ? 4'hF : 4'h1) : 4'h0;
      xoe_hi = (xb && !m_rd && !m_stk && m_tgt[1]) ? (m_quad ? 4'hF : 4'h1) : 4'h0;
      xtr = (!xb && start && cfg_good(b_stk, b_tgt, b_stripe, b_len) && !b_rd) ||
            (m_cnt > 1 && !m_rd && (idx % m_cpb) == m_cpb - 1);
      chk(busy == xb, xb ? "R2 busy" : "R1 busy", busy, xb);
      chk(sclk == (xb && idx[0]), xb ? "R2 sclk" : "R1 sclk", sclk, xb && idx[0]);
      chk(cs_lo_n == !(xb && (!m_stk || m_tgt == 2'b01)), m_stk ? "R4 cs_lo" : "R3 cs_lo",
          cs_lo_n, !(xb && (!m_stk || m_tgt == 2'b01)));
      chk(cs_hi_n == !(xb && (!m_stk || m_tgt == 2'b10)), m_stk ? "R4 cs_hi" : "R3 cs_hi",
          cs_hi_n, !(xb && (!m_stk || m_tgt == 2'b10)));
      chk(io_lo_oe == xoe_lo, "R7 lo oe", io_lo_oe, xoe_lo);
      chk(io_hi_oe == xoe_hi, "R7 hi oe", io_hi_oe, xoe_hi);
      chk(rx_valid == m_rxv, "R8 rx_valid timing", rx_valid, m_rxv);
      chk(err == m_err, "R10 err", err, m_err);
      chk(tx_req == xtr, "R12 tx_req", tx_req, xtr);
      if (sclk && io_lo_oe != 0) begin
        if (m_quad) begin acc_lo = {acc_lo[3:0], io_lo_o}; nb_lo += 4; end
        else        begin acc_lo = {acc_lo[6:0], io_lo_o[0]}; nb_lo += 1; end
        if (nb_lo == 8) begin q_lo.push_back(acc_lo); nb_lo = 0; end
      end
      if (sclk && io_hi_oe != 0) begin
        if (m_quad) begin acc_hi = {acc_hi[3:0], io_hi_o}; nb_hi += 4; end
        else        begin acc_hi = {acc_hi[6:0], io_hi_o[0]}; nb_hi += 1; end
        if (nb_hi == 8) begin q_hi.push_back(acc_hi); nb_hi = 0; end
      end
      if (rx_valid) q_rx.push_back(rx_data);
    end
  end

  task automatic xfer(input logic stk, input logic [1:0] tgt, input logic stripe, input logic quad,
                      input logic rd, input int len, input int seed, input string tag, input bit mid_start);
    logic [7:0] e_lo[$], e_hi[$];
    logic [15:0] e_rx[$];
    int beats;
    for (int k = 0; k < 64; k++) txb[k] = 8'(seed + k * 37 + 5);
    for (int k = 0; k < 32; k++) begin rlo[k] = 8'(seed * 3 + k * 29 + 1); rhi[k] = 8'(seed + k * 53 + 200); end
    q_lo.delete(); q_hi.delete(); q_rx.delete(); nb_lo = 0; nb_hi = 0;
    b_stk = stk; b_tgt = tgt; b_stripe = stripe; b_quad = quad; b_rd = rd; b_len = LW'(len);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (mid_start) begin
      repeat (5) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;   // R11: ignored while busy
    end
    while (m_cnt != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    beats = stripe ? len / 2 : len;
    if (!rd) begin
      for (int k = 0; k < len; k++) begin
        if (stripe) begin
          if (k % 2 == 0) e_lo.push_back(txb[k]); else e_hi.push_back(txb[k]);
        end else if (stk) e_lo.push_back(txb[k]);
        else begin
          if (tgt[0]) e_lo.push_back(txb[k]);
          if (tgt[1]) e_hi.push_back(txb[k]);
        end
      end
      chk(q_lo.size() == e_lo.size(), {tag, " lo count"}, q_lo.size(), e_lo.size());
      chk(q_hi.size() == e_hi.size(), {tag, " hi count"}, q_hi.size(), e_hi.size());
      foreach (e_lo[k]) if (k < q_lo.size()) chk(q_lo[k] == e_lo[k], {tag, " lo byte"}, q_lo[k], e_lo[k]);
      foreach (e_hi[k]) if (k < q_hi.size()) chk(q_hi[k] == e_hi[k], {tag, " hi byte"}, q_hi[k], e_hi[k]);
    end else begin
      for (int j = 0; j < beats; j++) begin
        if (stripe) e_rx.push_back({rhi[j], rlo[j]});
        else if (!stk && tgt == 2'b10) e_rx.push_back({8'h00, rhi[j]});
        else e_rx.push_back({8'h00, rlo[j]});
      end
      chk(q_rx.size() == e_rx.size(), {tag, " rx count"}, q_rx.size(), e_rx.size());
      foreach (e_rx[k]) if (k < q_rx.size()) chk(q_rx[k] == e_rx[k], {tag, " rx data"}, q_rx[k], e_rx[k]);
    end
  endtask

  task automatic refuse(input logic stk, input logic [1:0] tgt, input logic stripe, input int len, input bit clr);
    b_stk = stk; b_tgt = tgt; b_stripe = stripe; b_len = LW'(len); b_rd = 1'b0; b_quad = 1'b1;
    start = 1'b1; err_clr = clr;
    @(negedge clk); start = 1'b0; err_clr = 1'b0;
    chk(err == 1'b1, "R9 err after refusal", err, 1);
    chk(busy == 1'b0, "R9 no transfer", busy, 0);
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R9 still idle", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(cs_lo_n && cs_hi_n && !sclk && io_lo_oe == 0 && io_hi_oe == 0 && !busy && !err,
        "R1 reset state", {cs_lo_n, cs_hi_n, sclk, busy, err}, 5'b11000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    xfer(0, 2'b11, 0, 1, 0, 4, 1,  "R6 mirror quad write", 0);
    xfer(0, 2'b11, 1, 1, 0, 6, 2,  "R5 stripe quad write", 0);
    xfer(0, 2'b11, 1, 0, 0, 2, 3,  "R5 stripe single write", 0);
    xfer(0, 2'b11, 1, 1, 1, 4, 4,  "R5 stripe quad read", 0);
    xfer(0, 2'b01, 0, 0, 0, 2, 5,  "R3 lower single write", 0);
    xfer(0, 2'b10, 0, 0, 1, 3, 6,  "R8 upper single read", 0);
    xfer(0, 2'b11, 0, 1, 1, 2, 7,  "R6 mirror read lower", 0);
    xfer(1, 2'b01, 0, 1, 0, 3, 8,  "R4 stacked lower write", 0);
    xfer(1, 2'b10, 0, 0, 1, 2, 9,  "R4 stacked upper read", 0);
    xfer(1, 2'b10, 0, 1, 0, 2, 10, "R4 stacked upper write", 0);
    xfer(0, 2'b10, 0, 1, 0, 3, 11, "R11 start while busy", 1);
    refuse(0, 2'b11, 1, 5, 0);
    refuse(1, 2'b11, 0, 2, 0);
    chk(err == 1'b1, "R10 err held", err, 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk(err == 1'b0, "R10 err cleared", err, 0);
    refuse(0, 2'b00, 0, 2, 1);
    refuse(0, 2'b11, 0, 0, 0);
    refuse(0, 2'b01, 1, 2, 0);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    xfer(0, 2'b11, 1, 1, 0, 2, 12, "R2 after refusals", 0);
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule